// File: doc/BRIEF.md
# Three-Approach Junction Green Controller

This block drives the green lamps of a junction with three approaches: north, south and west. No traffic turns. North and south run on opposite sides of one road, so they can be green together. West crosses both and must never be green while either of them is.

Each approach has a traffic-sense input. The first time an approach senses traffic, it latches a request and steps through a four-phase sequence: idle, entering, critical and exiting. It shows green for as long as it holds the critical phase.

Two group locks keep the groups apart. One lock covers north and south together; the other covers west. A single turn token picks the group that wins when both groups are waiting. Per-approach done flags let the north-south group hand the token to west once both of its members have had a turn. Together these give every sensed approach service without forcing a fixed rotation.

All state changes on the rising clock edge. Reset is synchronous and active low.

Top module: `junction_signal_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released with no traffic sensed, all three green outputs are low. After reset the turn token favours the north-south group, and every lock, request, done flag and green is clear.
- R2: A sense input that is high for a single sampled cycle still latches a request. The approach then goes green and afterwards returns to idle on its own.
- R3: With nothing in its way, an approach goes green on the third rising edge after its sense input is first sampled high. Green is set on the edge that grants entry to the critical phase.
- R4: Green stays high while the sense input stays high. Once the sense input is sampled low in the critical phase, green falls on the second rising edge. The request is cleared on that same edge.
- R5: North and south may be green at the same time. An approach from that group can join while its partner is already green.
- R6: West green is never high in the same cycle as north or south green, and the two group locks are never held together.
- R7: The north-south lock is held while north or south is green. It is released only when the last green member of the group leaves, and west cannot enter before that.
- R8: North or south may enter only if the west lock is free and either the token is on north-south or west has no request. West may enter only if the north-south lock is free and either the token is on west or neither north nor south has a request. When both groups could enter on the same edge, the token holder wins.
- R9: When north or south exits while the token is on north-south, the token passes to west if the partner has no request, or if the partner is done and west has a request. When west exits holding the token, the token returns to north-south.
- R10: A north or south approach sets its done flag when it exits. A west exit clears both the north and the south done flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| sense_n | input | 1 | Traffic sensed on the north approach |
| sense_s | input | 1 | Traffic sensed on the south approach |
| sense_w | input | 1 | Traffic sensed on the west approach |
| green_n | output | 1 | North green lamp |
| green_s | output | 1 | South green lamp |
| green_w | output | 1 | West green lamp |

## Verification
Each kind of internal fault shows at the green outputs, and within a few cycles:
- A wrong lock or token value shows up as an approach that stays red although its way is clear, or as west green overlapping a north or south green. Either is visible within two edges of the exit that should have released the waiting group.
- A done flag that is not set or not cleared changes which group wins the next contest. The bench therefore re-requests the north approach while west waits, and checks whose lamp lights.
- A request that is not latched, or a phase skipped, moves the rising edge of green away from its three-edge latency. The bench checks that latency on the exact edge.

// File: rtl/junction_signal_ctrl.sv
module junction_signal_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic sense_n,
  input  logic sense_s,
  input  logic sense_w,
  output logic green_n,
  output logic green_s,
  output logic green_w
);

  localparam logic [1:0] PH_IDLE  = 2'd0;
  localparam logic [1:0] PH_ENTER = 2'd1;
  localparam logic [1:0] PH_CRIT  = 2'd2;
  localparam logic [1:0] PH_EXIT  = 2'd3;

  logic [1:0] ph_n, ph_s, ph_w;
  logic       req_n, req_s, req_w;
  logic       done_n, done_s;
  logic       lock_ns, lock_w;
  logic       turn_w;

  logic grant_n, grant_s, grant_w;
  logic exit_n, exit_s, exit_w;
  logic rel_ns, pass_to_w, pass_to_ns;

  function automatic logic [1:0] step(input logic [1:0] ph, input logic req,
                                      input logic sense, input logic grant);
    logic [1:0] nx;
    nx = ph;
    case (ph)
      PH_IDLE:  if (req)    nx = PH_ENTER;
      PH_ENTER: if (grant)  nx = PH_CRIT;
      PH_CRIT:  if (!sense) nx = PH_EXIT;
      default:              nx = PH_IDLE;
    endcase
    return nx;
  endfunction

  assign exit_n = (ph_n == PH_EXIT);
  assign exit_s = (ph_s == PH_EXIT);
  assign exit_w = (ph_w == PH_EXIT);

  assign grant_n = (ph_n == PH_ENTER) && !lock_w && (!turn_w || !req_w);
  assign grant_s = (ph_s == PH_ENTER) && !lock_w && (!turn_w || !req_w);
  assign grant_w = (ph_w == PH_ENTER) && !lock_ns && (turn_w || !(req_n || req_s))
                   && !(grant_n || grant_s);

  assign rel_ns = (exit_n && (!green_s || exit_s)) || (exit_s && (!green_n || exit_n));

  assign pass_to_w = !turn_w &&
                     ((exit_n && (!req_s || (done_s && req_w))) ||
                      (exit_s && (!req_n || (done_n && req_w))));
  assign pass_to_ns = turn_w && exit_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_n <= PH_IDLE; ph_s <= PH_IDLE; ph_w <= PH_IDLE;
      req_n <= 1'b0; req_s <= 1'b0; req_w <= 1'b0;
      done_n <= 1'b0; done_s <= 1'b0;
      lock_ns <= 1'b0; lock_w <= 1'b0;
      turn_w <= 1'b0;
      green_n <= 1'b0; green_s <= 1'b0; green_w <= 1'b0;
    end else begin
      ph_n <= step(ph_n, req_n, sense_n, grant_n);
      ph_s <= step(ph_s, req_s, sense_s, grant_s);
      ph_w <= step(ph_w, req_w, sense_w, grant_w);

      req_n <= exit_n ? 1'b0 : (sense_n ? 1'b1 : req_n);
      req_s <= exit_s ? 1'b0 : (sense_s ? 1'b1 : req_s);
      req_w <= exit_w ? 1'b0 : (sense_w ? 1'b1 : req_w);

      green_n <= grant_n ? 1'b1 : (exit_n ? 1'b0 : green_n);
      green_s <= grant_s ? 1'b1 : (exit_s ? 1'b0 : green_s);
      green_w <= grant_w ? 1'b1 : (exit_w ? 1'b0 : green_w);

      if (grant_n || grant_s) lock_ns <= 1'b1;
      else if (rel_ns)        lock_ns <= 1'b0;

      if (grant_w)     lock_w <= 1'b1;
      else if (exit_w) lock_w <= 1'b0;

      if (pass_to_w)       turn_w <= 1'b1;
      else if (pass_to_ns) turn_w <= 1'b0;

      done_n <= exit_w ? 1'b0 : (exit_n ? 1'b1 : done_n);
      done_s <= exit_w ? 1'b0 : (exit_s ? 1'b1 : done_s);
    end
  end

endmodule

// File: rtl/junction_signal_ctrl_sva.sv
module junction_signal_ctrl_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       green_n,
  input logic       green_s,
  input logic       green_w,
  input logic [1:0] ph_n,
  input logic [1:0] ph_w,
  input logic       req_n,
  input logic       req_s,
  input logic       done_n,
  input logic       done_s,
  input logic       lock_ns,
  input logic       lock_w,
  input logic       turn_w
);

  localparam logic [1:0] PH_ENTER = 2'd1;
  localparam logic [1:0] PH_EXIT  = 2'd3;

  AST_CROSS_GREEN: assert property (@(posedge clk) disable iff (!rst_n)
    !(green_w && (green_n || green_s))); // R6

  AST_LOCKS_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(lock_ns && lock_w)); // R6

  AST_NS_LOCK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (green_n || green_s) |-> lock_ns); // R7

  AST_GREEN_AT_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(green_n) |-> $past(ph_n) == PH_ENTER); // R3

  AST_EXIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_n == PH_EXIT) |=> (!green_n && !req_n)); // R4

  AST_WEST_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(green_w) |-> ($past(turn_w) || !($past(req_n) || $past(req_s)))); // R8

  AST_WEST_EXIT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_w == PH_EXIT) |=> (!done_n && !done_s && !turn_w)); // R10

endmodule

bind junction_signal_ctrl junction_signal_ctrl_sva u_sva (
  .clk(clk), .rst_n(rst_n),
  .green_n(green_n), .green_s(green_s), .green_w(green_w),
  .ph_n(ph_n), .ph_w(ph_w),
  .req_n(req_n), .req_s(req_s),
  .done_n(done_n), .done_s(done_s),
  .lock_ns(lock_ns), .lock_w(lock_w), .turn_w(turn_w)
);

// File: tb/junction_signal_ctrl_tb.sv
module junction_signal_ctrl_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sense_n = 1'b0, sense_s = 1'b0, sense_w = 1'b0;
  logic green_n, green_s, green_w;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  junction_signal_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .sense_n(sense_n), .sense_s(sense_s), .sense_w(sense_w),
    .green_n(green_n), .green_s(green_s), .green_w(green_w)
  );

  // entry: {sense n,s,w [9:7], edges to wait [6:3], expected greens n,s,w [2:0]}
  localparam int NV = 19;
  localparam logic [9:0] VEC [NV] = '{
    {3'b100, 4'd2, 3'b000},  // R3 not yet green
    {3'b100, 4'd1, 3'b100},  // R3 third edge
    {3'b110, 4'd3, 3'b110},  // R5 south joins
    {3'b111, 4'd5, 3'b110},  // R6 west held off
    {3'b011, 4'd2, 3'b010},  // R4 R7 north leaves, lock kept
    {3'b001, 4'd2, 3'b000},  // R7 last member leaves
    {3'b001, 4'd1, 3'b001},  // R9 token to west, west in
    {3'b101, 4'd4, 3'b001},  // R6 north waits
    {3'b100, 4'd2, 3'b000},  // R4 west leaves
    {3'b100, 4'd1, 3'b100},  // R9 token back, north in
    {3'b000, 4'd2, 3'b000},  // R9 north leaves, passes token
    {3'b101, 4'd3, 3'b001},  // R8 contest: token on west
    {3'b101, 4'd3, 3'b001},  // R8 north still waits
    {3'b100, 4'd2, 3'b000},  // R4 west off
    {3'b100, 4'd1, 3'b100},  // R8 north served
    {3'b100, 4'd6, 3'b100},  // R4 held while sensed
    {3'b000, 4'd1, 3'b100},  // R4 still green one edge after
    {3'b000, 4'd1, 3'b000},  // R4 dropped on second edge
    {3'b000, 4'd3, 3'b000}   // R1 idle again
  };

  task automatic check(input logic [2:0] exp, input string tag);
    n_cmp++;
    if ({green_n, green_s, green_w} !== exp) begin
      n_bad++;
      $display("FAIL %s: greens n,s,w = %b, expected %b", tag,
               {green_n, green_s, green_w}, exp);
    end
  endtask

  task automatic apply(input logic [2:0] s, input int edges, input logic [2:0] exp,
                       input string tag);
    {sense_n, sense_s, sense_w} = s;
    repeat (edges) @(posedge clk);
    @(negedge clk);
    check(exp, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    {sense_n, sense_s, sense_w} = 3'b000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run hung, actual running, expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1 greens stay low in reset even with traffic on every approach
    @(negedge clk);
    {sense_n, sense_s, sense_w} = 3'b111;
    repeat (4) @(negedge clk);
    check(3'b000, "R1 in reset");
    {sense_n, sense_s, sense_w} = 3'b000;
    rst_n = 1'b1;
    apply(3'b000, 3, 3'b000, "R1 after reset");

    for (int i = 0; i < NV; i++)
      apply(VEC[i][9:7], int'(VEC[i][6:3]), VEC[i][2:0], "R3-table vector");

    // R2 single-cycle pulse latched
    do_reset();
    apply(3'b100, 1, 3'b000, "R2 pulse edge");
    apply(3'b000, 2, 3'b100, "R2 green after pulse");
    apply(3'b000, 2, 3'b000, "R2 returns idle");

    // R1 token reset value: north wins a simultaneous contest
    do_reset();
    apply(3'b101, 3, 3'b100, "R1 token on north-south");
    apply(3'b001, 2, 3'b000, "R9 north exits");
    apply(3'b001, 1, 3'b001, "R9 west served");
    apply(3'b000, 2, 3'b000, "R4 west clears");

    // R10 partner done plus west waiting moves token to west
    do_reset();
    apply(3'b110, 3, 3'b110, "R5 both green");
    apply(3'b111, 3, 3'b110, "R7 west blocked");
    apply(3'b101, 2, 3'b100, "R10 south exits, done set");
    apply(3'b111, 3, 3'b110, "R5 south rejoins");
    apply(3'b011, 2, 3'b010, "R10 north exits");
    apply(3'b111, 4, 3'b010, "R10 north blocked by token");
    apply(3'b101, 2, 3'b000, "R7 lock released");
    apply(3'b101, 1, 3'b001, "R9 west enters");
    apply(3'b100, 2, 3'b000, "R10 west exits");
    apply(3'b100, 1, 3'b100, "R9 north served");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule